// File: doc/BRIEF.md
# Self-Programming Command Arming Controller

This block sits between the processor core and the flash programming engine. On-chip code writes an 8-bit control register to arm one self-programming operation: temporary buffer fill, page erase, page write, lock-bit set, lock/fuse read, or re-enabling reads of the application section. The armed operation is carried out only if the matching instruction strobe arrives within a short, cycle-counted window after the register write. Otherwise the armed bits clear themselves.

When a store strobe or a load strobe lands inside its window, the block issues exactly one single-cycle command pulse. It also registers the page, word and byte indexes decoded from the 16-bit address pointer. While an EEPROM write is in progress, register writes are refused and lock/fuse reads are held off. This keeps flash programming from starting during an EEPROM write.

Top module: `spm_arm_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, every command pulse is low, and `addr_err` is low.
- R2: `reg_rdata[7:5]` always read zero. The application-busy bit (bit 6) never sets. A write with bit 0 (enable) set makes bits 4:0 read back as written: bit 4 application read enable, bit 3 lock-bit set, bit 2 page write, bit 1 page erase, bit 0 enable. A write with bit 0 clear leaves bits 4:0 all zero.
- R3: A register write is taken at rising edge E0. A store strobe sampled at edge E1, E2, E3 or E4 issues a command. A store strobe at E5 or later issues nothing.
- R4: A store strobe issues only one pulse, chosen in this priority: lock-bit set, then application read enable, then page write, then page erase, then buffer fill (enable alone).
- R5: A load strobe issues a lock/fuse read pulse only when the lock-bit set bit is armed and the strobe is sampled at E1 through E5. A load strobe without lock-bit set arming issues nothing.
- R6: All armed bits clear at the edge where a command issues. They also clear at the last edge of the window: E4 normally, E5 when lock-bit set is armed. A load strobe that issues nothing does not clear the arming.
- R7: While `ee_busy` is high, register writes are ignored. A load strobe issues no lock/fuse read and leaves the arming in place.
- R8: For an issued command other than lock-bit set or lock read, `page_idx` = pointer bits 13:7, `word_idx` = bits 6:1, and `byte_sel` = bit 0. Pointer bits 15:14 have no effect.
- R9: For lock-bit set, `page_idx`, `word_idx` and `byte_sel` are zero. For lock read, `page_idx` and `word_idx` are zero.
- R10: A page write issued with nonzero pointer bits 6:1 still pulses, and it sets `addr_err`. `addr_err` stays set until reset.
- R11: Command pulses are registered one clock after the accepting edge. They last exactly one cycle, and at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| spm_stb | input | 1 | Store-to-program-memory instruction strobe |
| lpm_stb | input | 1 | Load-from-program-memory instruction strobe |
| zptr | input | 16 | Address pointer |
| ee_busy | input | 1 | EEPROM write in progress |
| cmd_fill | output | 1 | Temporary buffer fill pulse |
| cmd_erase | output | 1 | Page erase pulse |
| cmd_write | output | 1 | Page write pulse |
| cmd_rww | output | 1 | Application read re-enable pulse |
| cmd_lockset | output | 1 | Lock-bit set pulse |
| cmd_lockread | output | 1 | Lock/fuse read pulse |
| page_idx | output | 7 | Page index of the last issued command |
| word_idx | output | 6 | Word index of the last issued command |
| byte_sel | output | 1 | Byte select of the last issued command |
| addr_err | output | 1 | Sticky page-write word-bits error |

## Verification
The hardest case to reach is the fifth edge of a lock-bit arming. At that edge a store is refused but a load is still accepted. Reaching it needs the register write, the idle gap and the strobe placed with single-cycle accuracy. The bench sweeps every combination of command bits against every strobe delay from zero to five cycles, for both strobe kinds, so this edge is hit for both strobes. Separate sequences raise `ee_busy` part-way through a lock arming to show that a blocked load keeps the window alive for a later load.

// File: rtl/spm_arm_pkg.sv
`timescale 1ns/1ps
// Package spm_arm_pkg
// Shared types for the self-programming arming controller.
// Assumes: the control field layout below matches the register bits 4:0.
package spm_arm_pkg;

    typedef struct packed {
        logic rww;     // bit 4: application read re-enable
        logic lock;    // bit 3: lock-bit set / lock read
        logic write;   // bit 2: page write
        logic erase;   // bit 1: page erase
        logic en;      // bit 0: master enable
    } spm_ctl_t;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_FILL,
        OP_ERASE,
        OP_WRITE,
        OP_RWW,
        OP_LOCKSET,
        OP_LOCKREAD
    } spm_op_e;

endpackage

// File: rtl/spm_window.sv
`timescale 1ns/1ps
// Module spm_window
// Counts cycles since the arming write and tells which strobes are still
// accepted. It closes when a command is consumed or the last cycle passes.
// Assumes: LOAD_WIN >= STORE_WIN >= 1.
module spm_window #(
    parameter int STORE_WIN = 4,
    parameter int LOAD_WIN  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic lock_mode,
    input  logic consume,
    output logic store_open,
    output logic load_open,
    output logic closing
);
    localparam int AGE_W = $clog2(LOAD_WIN + 1);
    localparam logic [AGE_W-1:0] STORE_LAST = AGE_W'(STORE_WIN - 1);
    localparam logic [AGE_W-1:0] LOAD_LAST  = AGE_W'(LOAD_WIN - 1);

    logic [AGE_W-1:0] age_q;
    logic             act_q;
    logic [AGE_W-1:0] last_age;

    // last accepted age depends on whether a lock arming allows the longer load window
    assign last_age   = lock_mode ? LOAD_LAST : STORE_LAST;
    assign store_open = act_q && (age_q <= STORE_LAST);
    assign load_open  = act_q && (age_q <= LOAD_LAST);
    assign closing    = act_q && (consume || (age_q == last_age));

    // window state: restart on arming, end on use or expiry, otherwise age
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            age_q <= '0;
        end else if (start) begin
            act_q <= 1'b1;
            age_q <= '0;
        end else if (closing) begin
            act_q <= 1'b0;
            age_q <= '0;
        end else if (act_q) begin
            age_q <= age_q + 1'b1;
        end
    end
endmodule

// File: rtl/spm_cmd_sel.sv
`timescale 1ns/1ps
// Module spm_cmd_sel
// Chooses the single operation to issue from the armed bits and the strobes.
// Assumes: load_hit is already qualified by lock arming and EEPROM idle.
module spm_cmd_sel
    import spm_arm_pkg::*;
(
    input  spm_ctl_t ctl,
    input  logic     store_hit,
    input  logic     load_hit,
    output spm_op_e  op
);
    // fixed priority: lock set, read re-enable, write, erase, fill
    always_comb begin
        op = OP_NONE;
        if (store_hit && ctl.en) begin
            if (ctl.lock)       op = OP_LOCKSET;
            else if (ctl.rww)   op = OP_RWW;
            else if (ctl.write) op = OP_WRITE;
            else if (ctl.erase) op = OP_ERASE;
            else                op = OP_FILL;
        end else if (load_hit) begin
            op = OP_LOCKREAD;
        end
    end
endmodule

// File: rtl/spm_addr_dec.sv
`timescale 1ns/1ps
// Module spm_addr_dec
// Splits the address pointer into byte, word and page fields.
// Assumes: ADDR_W >= 1 + WORD_W + PAGE_W; bits above the page field are unused.
module spm_addr_dec #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 7,
    parameter int WORD_W = 6
) (
    input  logic [ADDR_W-1:0] zptr,
    output logic [PAGE_W-1:0] page,
    output logic [WORD_W-1:0] word,
    output logic              byte_bit,
    output logic              word_nz
);
    localparam int WORD_LSB = 1;
    localparam int PAGE_LSB = WORD_LSB + WORD_W;
    localparam int USED_W   = PAGE_LSB + PAGE_W;

    logic unused_hi;

    // field extraction; high bits are folded into an unused marker
    always_comb begin
        byte_bit  = zptr[0];
        word      = zptr[WORD_LSB +: WORD_W];
        page      = zptr[PAGE_LSB +: PAGE_W];
        word_nz   = |word;
        unused_hi = ^zptr[ADDR_W-1:USED_W];
    end
endmodule

// File: rtl/spm_arm_ctrl.sv
`timescale 1ns/1ps
// Module spm_arm_ctrl (top)
// Holds the armed control bits and runs the strobe window. It issues one
// registered command pulse with decoded indexes and flags page writes that
// have nonzero word bits. Assumes: strobes are single-cycle, synchronous to clk.
module spm_arm_ctrl
    import spm_arm_pkg::*;
#(
    parameter int STORE_WIN = 4,
    parameter int LOAD_WIN  = 5,
    parameter int PAGE_W    = 7,
    parameter int WORD_W    = 6,
    parameter int ADDR_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              spm_stb,
    input  logic              lpm_stb,
    input  logic [ADDR_W-1:0] zptr,
    input  logic              ee_busy,
    output logic              cmd_fill,
    output logic              cmd_erase,
    output logic              cmd_write,
    output logic              cmd_rww,
    output logic              cmd_lockset,
    output logic              cmd_lockread,
    output logic [PAGE_W-1:0] page_idx,
    output logic [WORD_W-1:0] word_idx,
    output logic              byte_sel,
    output logic              addr_err
);
    localparam int CTL_W = $bits(spm_ctl_t);

    spm_ctl_t          ctl_q;
    spm_op_e           op;
    logic              wr_ok, start, store_open, load_open, closing;
    logic              store_hit, load_hit, consume;
    logic [PAGE_W-1:0] dec_page;
    logic [WORD_W-1:0] dec_word;
    logic              dec_byte, dec_word_nz;
    logic              unused_wdata;

    // write qualification and strobe hits
    always_comb begin
        wr_ok        = reg_we && !ee_busy;
        start        = wr_ok && reg_wdata[0];
        store_hit    = spm_stb && store_open;
        load_hit     = lpm_stb && load_open && ctl_q.lock && !ee_busy;
        consume      = (op != OP_NONE);
        unused_wdata = ^reg_wdata[7:CTL_W];
    end

    spm_window #(.STORE_WIN(STORE_WIN), .LOAD_WIN(LOAD_WIN)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .lock_mode  (ctl_q.lock),
        .consume    (consume),
        .store_open (store_open),
        .load_open  (load_open),
        .closing    (closing)
    );

    spm_cmd_sel u_sel (
        .ctl       (ctl_q),
        .store_hit (store_hit),
        .load_hit  (load_hit),
        .op        (op)
    );

    spm_addr_dec #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_dec (
        .zptr     (zptr),
        .page     (dec_page),
        .word     (dec_word),
        .byte_bit (dec_byte),
        .word_nz  (dec_word_nz)
    );

    // armed bits: loaded by an accepted write, cleared when the window closes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ok) begin
            ctl_q <= reg_wdata[0] ? spm_ctl_t'(reg_wdata[CTL_W-1:0]) : '0;
        end else if (closing) begin
            ctl_q <= '0;
        end
    end

    // registered command pulses, indexes and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_fill     <= 1'b0;
            cmd_erase    <= 1'b0;
            cmd_write    <= 1'b0;
            cmd_rww      <= 1'b0;
            cmd_lockset  <= 1'b0;
            cmd_lockread <= 1'b0;
            page_idx     <= '0;
            word_idx     <= '0;
            byte_sel     <= 1'b0;
            addr_err     <= 1'b0;
        end else begin
            cmd_fill     <= (op == OP_FILL);
            cmd_erase    <= (op == OP_ERASE);
            cmd_write    <= (op == OP_WRITE);
            cmd_rww      <= (op == OP_RWW);
            cmd_lockset  <= (op == OP_LOCKSET);
            cmd_lockread <= (op == OP_LOCKREAD);
            if (op == OP_LOCKSET) begin
                page_idx <= '0;
                word_idx <= '0;
                byte_sel <= 1'b0;
            end else if (op == OP_LOCKREAD) begin
                page_idx <= '0;
                word_idx <= '0;
                byte_sel <= dec_byte;
            end else if (consume) begin
                page_idx <= dec_page;
                word_idx <= dec_word;
                byte_sel <= dec_byte;
            end
            if (op == OP_WRITE && dec_word_nz) addr_err <= 1'b1;
        end
    end

    // read path: bits 7:5 (reserved and application-busy) are always zero
    assign reg_rdata = {{(8-CTL_W){1'b0}}, ctl_q};
endmodule

// File: rtl/spm_arm_ctrl_chk.sv
`timescale 1ns/1ps
// Module spm_arm_ctrl_chk
// Port-level properties of the arming controller, bound into every instance.
module spm_arm_ctrl_chk #(
    parameter int PAGE_W = 7,
    parameter int WORD_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic              ee_busy,
    input logic              lpm_stb,
    input logic [7:0]        reg_rdata,
    input logic              cmd_fill,
    input logic              cmd_erase,
    input logic              cmd_write,
    input logic              cmd_rww,
    input logic              cmd_lockset,
    input logic              cmd_lockread,
    input logic [PAGE_W-1:0] page_idx,
    input logic [WORD_W-1:0] word_idx,
    input logic              addr_err
);
    logic [5:0] pulses;
    assign pulses = {cmd_lockread, cmd_lockset, cmd_rww, cmd_write, cmd_erase, cmd_fill};

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(pulses)); // R11
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reg_rdata[7:5] == 3'b000); // R2
    AST_NO_CMD_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata[0] == 1'b0) |=> (pulses == 6'b0)); // R3
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && ee_busy && reg_rdata == 8'h00) |=> (reg_rdata == 8'h00)); // R7
    AST_BUSY_NO_LOCKREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_busy && lpm_stb) |=> !cmd_lockread); // R7
    AST_PULSE_CLEARS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        ((pulses != 6'b0) && !$past(reg_we)) |-> (reg_rdata == 8'h00)); // R6
    AST_LOCK_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_lockset || cmd_lockread) |-> (page_idx == '0 && word_idx == '0)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) addr_err |=> addr_err); // R10
endmodule

bind spm_arm_ctrl spm_arm_ctrl_chk #(.PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/spm_arm_ctrl_bench.sv
`timescale 1ns/1ps
// Bench for spm_arm_ctrl: sweeps command bits x strobe delay x strobe kind.
module spm_arm_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [7:0]  reg_rdata;
    logic        spm_stb = 1'b0;
    logic        lpm_stb = 1'b0;
    logic [15:0] zptr = 16'h0000;
    logic        ee_busy = 1'b0;
    logic        cmd_fill, cmd_erase, cmd_write, cmd_rww, cmd_lockset, cmd_lockread;
    logic [6:0]  page_idx;
    logic [5:0]  word_idx;
    logic        byte_sel, addr_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic exp_err = 1'b0;

    always #2.5 clk = ~clk;

    spm_arm_ctrl u_spm_arm_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .spm_stb(spm_stb), .lpm_stb(lpm_stb), .zptr(zptr),
        .ee_busy(ee_busy), .cmd_fill(cmd_fill), .cmd_erase(cmd_erase),
        .cmd_write(cmd_write), .cmd_rww(cmd_rww), .cmd_lockset(cmd_lockset),
        .cmd_lockread(cmd_lockread), .page_idx(page_idx), .word_idx(word_idx),
        .byte_sel(byte_sel), .addr_err(addr_err)
    );

    function automatic logic [5:0] pulses();
        return {cmd_lockread, cmd_lockset, cmd_rww, cmd_write, cmd_erase, cmd_fill};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        exp_err = 1'b0;
    endtask

    // arm with ctl[4:0], wait d idle cycles, strobe once, then check
    task automatic trial(input logic [4:0] ctl, input int d, input bit use_load, input logic [15:0] z);
        bit         acc;
        logic [5:0] exp_p;
        int         lim;
        @(negedge clk);
        reg_we = 1'b1; reg_wdata = {3'b111, ctl}; zptr = z;
        @(negedge clk);
        reg_we = 1'b0;
        check("R2 readback", reg_rdata, {3'b000, ctl});
        repeat (d) @(negedge clk);
        if (use_load) lpm_stb = 1'b1; else spm_stb = 1'b1;
        @(negedge clk);
        lpm_stb = 1'b0; spm_stb = 1'b0;
        lim = ctl[3] ? 4 : 3;
        exp_p = 6'b0;
        if (use_load) begin
            acc = ctl[3] && (d <= 4);
            if (acc) exp_p[5] = 1'b1;
        end else begin
            acc = (d <= 3);
            if (acc) begin
                if (ctl[3])      exp_p[4] = 1'b1;
                else if (ctl[4]) exp_p[3] = 1'b1;
                else if (ctl[2]) exp_p[2] = 1'b1;
                else if (ctl[1]) exp_p[1] = 1'b1;
                else             exp_p[0] = 1'b1;
            end
        end
        check(use_load ? "R5 load pulse" : (d <= 3 ? "R4 store pulse" : "R3 late store"), pulses(), exp_p);
        check("R6 arm after strobe", reg_rdata, (!acc && d < lim) ? {3'b000, ctl} : 8'h00);
        if (acc) begin
            if (exp_p[4] || exp_p[5]) begin
                check("R9 lock indexes", {page_idx, word_idx}, 13'h0);
                check("R9 lock byte", byte_sel, exp_p[5] ? z[0] : 1'b0);
            end else begin
                check("R8 page", page_idx, z[13:7]);
                check("R8 word", word_idx, z[6:1]);
                check("R8 byte", byte_sel, z[0]);
            end
        end
        if (exp_p[2] && z[6:1] != 6'd0) exp_err = 1'b1;
        check("R10 error flag", addr_err, exp_err);
        @(negedge clk);
        check("R11 pulse width", pulses(), 6'b0);
        repeat (6) @(negedge clk);
        check("R6 window expired", reg_rdata, 8'h00);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 rdata", reg_rdata, 8'h00);
        check("R1 pulses", pulses(), 6'b0);
        check("R1 err", addr_err, 1'b0);

        // R2 write without enable leaves everything clear, and a store does nothing
        @(negedge clk) reg_we = 1'b1; reg_wdata = 8'hFE;
        @(negedge clk) reg_we = 1'b0; spm_stb = 1'b1;
        check("R2 no enable", reg_rdata, 8'h00);
        @(negedge clk) spm_stb = 1'b0;
        check("R2 no enable store", pulses(), 6'b0);

        // main sweep: R3 R4 R5 R6 R8 R9 R10 R11
        for (int c = 0; c < 16; c++)
            for (int d = 0; d < 6; d++)
                for (int ld = 0; ld < 2; ld++)
                    trial({c[3:0], 1'b1}, d, ld[0],
                          16'(c * 4099 + d * 771 + ld * 12345) ^ 16'hC0F3);

        // R7 write while busy is ignored
        repeat (2) @(negedge clk);
        ee_busy = 1'b1; reg_we = 1'b1; reg_wdata = 8'h05;
        @(negedge clk) reg_we = 1'b0; spm_stb = 1'b1;
        check("R7 busy write", reg_rdata, 8'h00);
        @(negedge clk) spm_stb = 1'b0; ee_busy = 1'b0;
        check("R7 busy write store", pulses(), 6'b0);

        // R7 busy blocks lock read but keeps arming; a later load succeeds
        @(negedge clk) reg_we = 1'b1; reg_wdata = 8'h09; zptr = 16'h0001;
        @(negedge clk) reg_we = 1'b0; ee_busy = 1'b1; lpm_stb = 1'b1;
        @(negedge clk) ee_busy = 1'b0;
        check("R7 blocked lock read", pulses(), 6'b0);
        check("R7 arm kept", reg_rdata, 8'h09);
        @(negedge clk) lpm_stb = 1'b0;
        check("R7 later lock read", pulses(), 6'b100000);
        check("R9 lock read byte", byte_sel, 1'b1);
        check("R6 cleared after read", reg_rdata, 8'h00);

        // R5 load without lock arming does nothing and keeps the arm
        repeat (3) @(negedge clk);
        reg_we = 1'b1; reg_wdata = 8'h03;
        @(negedge clk) reg_we = 1'b0; lpm_stb = 1'b1;
        @(negedge clk) lpm_stb = 1'b0;
        check("R5 plain load", pulses(), 6'b0);
        check("R6 plain load keeps arm", reg_rdata, 8'h03);
        repeat (6) @(negedge clk);

        // R10 sticky error after reset
        do_reset();
        check("R10 err cleared by reset", addr_err, 1'b0);
        trial(5'b00101, 1, 1'b0, 16'h3F84);
        check("R10 err set", addr_err, 1'b1);
        trial(5'b00001, 0, 1'b0, 16'h0000);
        check("R10 err sticky", addr_err, 1'b1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule